// File: doc/BRIEF.md
# Serial EEPROM Write-Cycle Ready/Busy Reporter

This block handles write-cycle timing and status reporting for the slave side of a three-wire serial EEPROM. It watches chip select, serial clock and serial data in, which are all asynchronous to the system clock, and drives the serial data out pin as a tri-state pad. The pin is modelled as a pair of ports: an output enable and an output level. When the block sees a complete write instruction followed by the fall of chip select, it starts a self-timed erase/write cycle. The cycle is a system-clock counter, so its length does not depend on the serial clock.

After a write has launched, chip select must drop and then rise again. If it stayed low for at least a set number of system clock cycles, the output pin reports the write state while chip select is high. The pin is driven low while the cycle runs and high once the cycle has ended. A command sent during the cycle is discarded. The start bit of a command sent during the ready phase is accepted, and it ends the status display. The array contents, the read path and analog timing checks are not part of this block.

Top module: `eeprom_rdy_busy`

## Requirements
- R1: During and right after reset the output enable `do_oe` is 0 and the output level `do_val` is 1.
- R2: A command begins at the first serial clock rise, with chip select high, that samples data-in as 1. Zeros clocked in before that bit are ignored.
- R3: A write is the start bit, then opcode bits 0 then 1 (MSB first), then ADDR_W address bits, then exactly 16 data bits, with chip select falling after the last data bit. Any other opcode or any other bit count does not start a write cycle.
- R4: The write cycle lasts exactly TWR_CYC system clock cycles. While it runs, `do_val` is 0. It falls 3 clock edges after the chip select fall that ends the write.
- R5: When the cycle expires, `do_val` returns to 1 and stays at 1 until another write is accepted.
- R6: After an accepted write, the status is shown (`do_oe`=1) only from a chip select rise that follows at least TCS_CYC synchronised low cycles. A rise after a shorter low time shows nothing, and the next proper low-then-high shows the status.
- R7: `do_oe` is 0 whenever synchronised chip select is low.
- R8: A command sent while the cycle runs has no effect. A further full write neither restarts nor extends the cycle, and a status display that was armed stays armed.
- R9: A start bit accepted while the cycle is not running removes the status display (`do_oe` falls). The status is not shown again until another write has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, asynchronous |
| sk | input | 1 | Serial clock, asynchronous |
| di | input | 1 | Serial data in, asynchronous |
| do_oe | output | 1 | Pad enable for serial data out (0 = high impedance) |
| do_val | output | 1 | Level driven on serial data out when enabled (0 busy, 1 ready) |

## Verification
A pin change driven before system clock edge k passes two synchroniser stages and one event register. Events on chip select, such as ending a write or revealing or hiding the status, therefore show on `do_oe` after edge k+2, and the busy level shows on `do_val` one edge later, after edge k+3. The bench drives every pin on the falling clock edge, and its reference model replays the same pin history with that latency. Both outputs are compared against the model on every falling edge. The directed checks wait exactly these counts: three edges before judging the display, and TWR_CYC+1-L low samples for a display revealed after L low cycles. The expiry edge is checked against the cycle count of the chip select fall that launched the write.

// File: rtl/eest_pkg.sv
package eest_pkg;

  // opcode that marks a programming command, first bit sent is bit 1
  localparam logic [1:0] OP_WRITE = 2'b01;

  // payload length of a write command
  localparam int DATA_W = 16;

  // synchronised view of the three serial pins
  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } pins_t;

endpackage

// File: rtl/eest_sync.sv
module eest_sync
  import eest_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  pins_t d,
  output pins_t q
);

  pins_t stage [SYNC_N];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar g = 1; g < SYNC_N; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else     stage[g] <= stage[g-1];
    end
  end

  assign q = stage[SYNC_N-1];

endmodule

// File: rtl/eest_rx.sv
module eest_rx
  import eest_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  pins_t pin,
  output logic  start,
  output logic  wr_req,
  output logic  cs_rise
);

  localparam int FRAME = 2 + ADDR_W + DATA_W;
  localparam int CW    = $clog2(FRAME + 2);

  logic          cs_p;
  logic          sk_p;
  logic          act;
  logic [CW-1:0] cnt;
  logic [1:0]    op;
  logic          sk_rise;
  logic          cs_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= 1'b0;
      sk_p <= 1'b0;
    end else begin
      cs_p <= pin.cs;
      sk_p <= pin.sk;
    end
  end

  assign sk_rise = pin.cs & pin.sk & ~sk_p;
  assign cs_fall = ~pin.cs & cs_p;
  assign cs_rise = pin.cs & ~cs_p;
  assign start   = sk_rise & ~act & pin.di;
  assign wr_req  = cs_fall & act & (cnt == CW'(FRAME)) & (op == OP_WRITE);

  // bit counter runs one past the frame so over-length commands are rejected
  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
      op  <= '0;
    end else if (!pin.cs) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (sk_rise) begin
      if (!act) begin
        if (pin.di) act <= 1'b1;
        cnt <= '0;
      end else if (cnt <= CW'(FRAME)) begin
        if (cnt == CW'(0)) op[1] <= pin.di;
        if (cnt == CW'(1)) op[0] <= pin.di;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sk_rise && !act && !pin.di) |=> !act);

  // R3
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> (!act && cnt == '0));

endmodule

// File: rtl/eest_timer.sv
module eest_timer #(
  parameter int TWR_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  output logic busy
);

  localparam int TW = (TWR_CYC > 1) ? $clog2(TWR_CYC + 1) : 1;

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (busy) begin
      if (tcnt == '0) busy <= 1'b0;
      else            tcnt <= tcnt - 1'b1;
    end else if (wr_req) begin
      busy <= 1'b1;
      tcnt <= TW'(TWR_CYC - 1);
    end
  end

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && tcnt != '0) |=> busy);

  // R5
  expire_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && tcnt == '0) |=> !busy);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_req && tcnt != '0) |=> (tcnt == $past(tcnt) - 1'b1));

endmodule

// File: rtl/eest_status.sv
module eest_status #(
  parameter int TCS_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic cs_rise,
  input  logic start,
  input  logic wr_req,
  input  logic busy,
  output logic do_oe,
  output logic do_val
);

  localparam int LW = $clog2(TCS_CYC + 1);

  logic [LW-1:0] low_cnt;
  logic          armed;
  logic          show;

  always_ff @(posedge clk) begin
    if (rst)                        low_cnt <= '0;
    else if (cs_s)                  low_cnt <= '0;
    else if (low_cnt < LW'(TCS_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                    armed <= 1'b0;
    else if (wr_req && !busy)   armed <= 1'b1;
    else if (start && !busy)    armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                  show <= 1'b0;
    else if (!cs_s)           show <= 1'b0;
    else if (cs_rise)         show <= armed && (low_cnt >= LW'(TCS_CYC));
    else if (start && !busy)  show <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) do_val <= 1'b1;
    else     do_val <= ~busy;
  end

  assign do_oe = show;

  // R7
  hide_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !show);

  // R6
  show_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(show) |-> ($past(armed) && $past(low_cnt) >= LW'(TCS_CYC)));

  // R9
  ready_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_s && !cs_rise && start && !busy) |=> !show);

endmodule

// File: rtl/eeprom_rdy_busy.sv
module eeprom_rdy_busy
  import eest_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int TWR_CYC = 500000,
  parameter int TCS_CYC = 20,
  parameter int SYNC_N  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_oe,
  output logic do_val
);

  pins_t raw;
  pins_t pin;
  logic  start;
  logic  wr_req;
  logic  cs_rise;
  logic  busy;

  assign raw = '{cs: cs, sk: sk, di: di};

  eest_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (pin)
  );

  eest_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .pin     (pin),
    .start   (start),
    .wr_req  (wr_req),
    .cs_rise (cs_rise)
  );

  eest_timer #(.TWR_CYC(TWR_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .wr_req (wr_req),
    .busy   (busy)
  );

  eest_status #(.TCS_CYC(TCS_CYC)) u_status (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (pin.cs),
    .cs_rise (cs_rise),
    .start   (start),
    .wr_req  (wr_req),
    .busy    (busy),
    .do_oe   (do_oe),
    .do_val  (do_val)
  );

  // R4
  busy_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !do_val);

endmodule

// File: tb/test_eeprom_rdy_busy.sv
module test_eeprom_rdy_busy;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 6;
  localparam int TWR_CYC = 300;
  localparam int TCS_CYC = 4;
  localparam int HALF    = 2;
  localparam int FRAME   = 2 + ADDR_W + 16;
  localparam int WDOG    = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_oe, do_val;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_rdy_busy #(
    .ADDR_W(ADDR_W), .TWR_CYC(TWR_CYC), .TCS_CYC(TCS_CYC), .SYNC_N(2)
  ) i_eeprom_rdy_busy (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
    .do_oe(do_oe), .do_val(do_val)
  );

  // ---------------- behavioural reference model ----------------
  logic hq_cs[$], hq_sk[$], hq_di[$];
  bit   m_act, m_busy, m_armed, m_show, m_doval;
  int   m_cnt, m_tcnt, m_low;
  bit [1:0] m_op;

  task automatic model_reset();
    hq_cs = '{0, 0, 0}; hq_sk = '{0, 0, 0}; hq_di = '{0, 0, 0};
    m_act = 0; m_busy = 0; m_armed = 0; m_show = 0; m_doval = 1;
    m_cnt = 0; m_tcnt = 0; m_low = 0; m_op = 2'b00;
  endtask

  task automatic model_step();
    bit c_now, c_old, k_now, k_old, d_now, skr, csf, csr, st, wr;
    bit n_act, n_busy, n_armed, n_show; int n_cnt, n_tcnt, n_low; bit [1:0] n_op;
    c_now = hq_cs[1]; c_old = hq_cs[2];
    k_now = hq_sk[1]; k_old = hq_sk[2]; d_now = hq_di[1];
    skr = c_now && k_now && !k_old;
    csf = !c_now && c_old;
    csr = c_now && !c_old;
    st  = skr && !m_act && d_now;
    wr  = csf && m_act && (m_cnt == FRAME) && (m_op == 2'b01);
    n_act = m_act; n_cnt = m_cnt; n_op = m_op;
    if (!c_now) begin n_act = 0; n_cnt = 0; end
    else if (skr) begin
      if (!m_act) begin n_act = d_now; n_cnt = 0; end
      else if (m_cnt <= FRAME) begin
        if (m_cnt == 0) n_op[1] = d_now;
        if (m_cnt == 1) n_op[0] = d_now;
        n_cnt = m_cnt + 1;
      end
    end
    n_busy = m_busy; n_tcnt = m_tcnt;
    if (m_busy) begin
      if (m_tcnt == 0) n_busy = 0; else n_tcnt = m_tcnt - 1;
    end else if (wr) begin n_busy = 1; n_tcnt = TWR_CYC - 1; end
    n_low = c_now ? 0 : ((m_low < TCS_CYC) ? m_low + 1 : m_low);
    n_armed = m_armed;
    if (wr && !m_busy) n_armed = 1; else if (st && !m_busy) n_armed = 0;
    n_show = m_show;
    if (!c_now) n_show = 0;
    else if (csr) n_show = m_armed && (m_low >= TCS_CYC);
    else if (st && !m_busy) n_show = 0;
    m_doval = !m_busy;
    m_act = n_act; m_cnt = n_cnt; m_op = n_op; m_busy = n_busy; m_tcnt = n_tcnt;
    m_low = n_low; m_armed = n_armed; m_show = n_show;
    hq_cs.push_front(cs); void'(hq_cs.pop_back());
    hq_sk.push_front(sk); void'(hq_sk.pop_back());
    hq_di.push_front(di); void'(hq_di.pop_back());
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) model_reset();
    else     model_step();
  end

  initial model_reset();

  // every-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (do_oe !== m_show || do_val !== m_doval) begin
        n_fail++;
        $display("FAIL %s cycle %0d: oe/val got %b%b expected %b%b",
                 cur_req, cyc, do_oe, do_val, m_show, m_doval);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic expect_bit(string req, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic expect_int(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    sk = 1'b0; di = b;
    repeat (HALF) @(negedge clk);
    sk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input int zeros, input logic [1:0] op, input int dbits,
                          input logic [ADDR_W-1:0] a, input logic [15:0] d);
    cs = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < zeros; i++) clk_bit(1'b0);
    clk_bit(1'b1);
    clk_bit(op[1]);
    clk_bit(op[0]);
    for (int i = ADDR_W - 1; i >= 0; i--) clk_bit(a[i]);
    for (int i = 0; i < dbits; i++) clk_bit(d[15 - (i % 16)]);
    sk = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_cycle(input int low_len);
    cs = 1'b0;
    repeat (low_len) @(negedge clk);
    cs = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int t_a, n_low;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_bit("R1", "oe after reset", do_oe, 1'b0);
    expect_bit("R1", "val after reset", do_val, 1'b1);

    // write A with leading zeros, then an early reassertion
    cur_req = "R2";
    send_cmd(2, 2'b01, 16, 6'h2a, 16'hc35a);
    cur_req = "R6";
    cs = 1'b0; t_a = cyc;
    repeat (TCS_CYC - 1) @(negedge clk);
    cs = 1'b1;
    repeat (6) @(negedge clk);
    expect_bit("R6", "oe after short low", do_oe, 1'b0);
    cs_cycle(TCS_CYC);
    repeat (3) @(negedge clk);
    expect_bit("R6", "oe after proper low", do_oe, 1'b1);
    expect_bit("R4", "busy level", do_val, 1'b0);

    // write B while busy, must change nothing
    cur_req = "R8";
    send_cmd(0, 2'b01, 16, 6'h15, 16'h1234);
    cs = 1'b0;
    repeat (3) @(negedge clk);
    expect_bit("R7", "oe while cs low", do_oe, 1'b0);
    repeat (TCS_CYC) @(negedge clk);
    cs = 1'b1;
    repeat (3) @(negedge clk);
    expect_bit("R8", "status still shown", do_oe, 1'b1);
    while (do_val !== 1'b1) @(negedge clk);
    expect_int("R8", "expiry edge", cyc, t_a + 4 + TWR_CYC);
    cur_req = "R5";
    repeat (10) @(negedge clk);
    expect_bit("R5", "ready level held", do_val, 1'b1);
    expect_bit("R5", "ready shown", do_oe, 1'b1);

    // read-style command while ready ends the display
    cur_req = "R9";
    send_cmd(1, 2'b10, 0, 6'h07, 16'h0000);
    expect_bit("R9", "oe after ready start", do_oe, 1'b0);
    cs_cycle(TCS_CYC);
    repeat (6) @(negedge clk);
    expect_bit("R9", "oe not re-shown", do_oe, 1'b0);

    // malformed writes
    cur_req = "R3";
    send_cmd(0, 2'b01, 15, 6'h01, 16'hffff);
    cs_cycle(TCS_CYC);
    repeat (6) @(negedge clk);
    expect_bit("R3", "short write ignored", do_oe, 1'b0);
    send_cmd(0, 2'b01, 17, 6'h01, 16'hffff);
    cs_cycle(TCS_CYC);
    repeat (6) @(negedge clk);
    expect_bit("R3", "long write ignored", do_oe, 1'b0);
    send_cmd(0, 2'b11, 16, 6'h01, 16'h8001);
    cs_cycle(TCS_CYC);
    repeat (6) @(negedge clk);
    expect_bit("R3", "other opcode ignored", do_oe, 1'b0);

    // write C, measure the busy window seen on the pin
    cur_req = "R4";
    send_cmd(3, 2'b01, 16, 6'h3f, 16'h0f0f);
    cs_cycle(TCS_CYC);
    repeat (3) @(negedge clk);
    n_low = 0;
    while (do_oe === 1'b1 && do_val === 1'b0) begin
      n_low++;
      @(negedge clk);
    end
    expect_int("R4", "low samples", n_low, TWR_CYC + 1 - TCS_CYC);
    expect_bit("R5", "ready after C", do_val, 1'b1);
    cs = 1'b0;
    repeat (3) @(negedge clk);
    expect_bit("R7", "oe after final cs fall", do_oe, 1'b0);
    repeat (5) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule